// File: doc/BRIEF.md
# Half-Precision Register Move and Box-Check Unit

This unit handles the register-file side of 16-bit floating-point data. Floating-point registers are FLEN bits wide (32 or 64) and integer registers are XLEN bits wide. The unit performs four moves:

- a half load places a 16-bit memory word into an f-register, with the upper bits padded with ones;
- a half store returns the low 16 bits of an f-register for memory;
- a move to integer copies the raw half encoding into an integer register, sign-extended;
- a move from integer boxes the low 16 integer bits into an f-register.

Alongside the move, the unit validates the f-register operand as a half value. It checks the box at every nesting width (a half inside a single inside a double). A broken box yields the boxed canonical half NaN.

Each operation is presented with a one-cycle `in_valid` strobe. Its results appear on registered outputs on the next clock edge, with `out_valid` high for that one cycle. When no operation is presented, the result registers keep their last values.

Top module: `hbox_move_unit`

## Requirements
- R1: While reset is asserted and after its release with no operation presented, `out_valid` is 0 and `f_result`, `x_result`, `st_data`, `chk_operand` and `box_ok` are all zero.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and the results of that operation are visible in that same cycle.
- R3: Half load (op 2'b00) sets `f_result` to FLEN-16 one bits above `ld_data`, with the data bits unaltered, including NaN payloads.
- R4: Half store (op 2'b01) sets `st_data` to `frs_data[15:0]` unaltered. The upper f-register bits are ignored, and a broken box does not change the stored value.
- R5: Move to integer (op 2'b10) sets `x_result` to `frs_data[15:0]` with bits XLEN-1..16 copied from bit 15. No box check is applied.
- R6: Move from integer (op 2'b11) sets `f_result` to FLEN-16 one bits above `xrs_data[15:0]`. The upper integer bits are ignored.
- R7: With `fmt` equal to 2'b10 (half), an operand whose upper FLEN-16 bits are all ones passes to `chk_operand` unchanged, and `box_ok` is 1.
- R8: With `fmt` equal to 2'b10, an operand with any zero among its upper FLEN-16 bits produces `chk_operand` = FLEN-16 ones above 16'h7E00, and `box_ok` is 0. This holds also for boxes that are valid only at the single-width level.
- R9: With `fmt` other than 2'b10, `chk_operand` equals `frs_data` and `box_ok` is 0.
- R10: Result outputs that the selected operation does not produce are zero: `f_result` for store and move-to-integer, `x_result` for load, store and move-from-integer, and `st_data` for all but store.
- R11: In a cycle with `in_valid` low, all result registers keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 2 | 00 load, 01 store, 10 move to integer, 11 move from integer |
| fmt | input | 2 | Operand format code; 2'b10 selects half box checking |
| frs_data | input | FLEN | f-register source value |
| xrs_data | input | XLEN | Integer register source value |
| ld_data | input | 16 | Half word returned from memory |
| out_valid | output | 1 | Results updated this cycle |
| f_result | output | FLEN | Value to write to the f-register |
| x_result | output | XLEN | Value to write to the integer register |
| st_data | output | 16 | Half word to send to memory |
| chk_operand | output | FLEN | Box-checked f-register operand |
| box_ok | output | 1 | Operand is a correctly boxed half |

## Verification
The assertions assume that `in_valid` is driven low during reset. They also assume that `op`, `fmt` and the data inputs are settled before each rising edge. The bench drives every input at the falling edge and keeps `in_valid` low throughout reset, which satisfies both. The box-check properties rely on `fmt` being stable across the cycle in which `in_valid` is high. Each vector therefore holds its format code for the full cycle.

// File: rtl/hbox_pkg.sv
package hbox_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_STORE    = 2'b01,
        OP_TO_INT   = 2'b10,
        OP_FROM_INT = 2'b11
    } hbox_op_e;

    localparam logic [1:0]  FMT_HALF  = 2'b10;
    localparam int          HALF_W    = 16;
    localparam logic [15:0] CANON_NAN = 16'h7E00;

endpackage

// File: rtl/hbox_box_check.sv
module hbox_box_check #(
    parameter int FLEN = 64
) (
    input  logic [FLEN-1:0] value,
    output logic            boxed
);
    // One level per doubling of width above the half: 32, 64, ...
    localparam int LEVELS = $clog2(FLEN) - 4;

    logic [LEVELS-1:0] level_ok;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int LO = 16 << lv;
        localparam int HI = (32 << lv) - 1;
        assign level_ok[lv] = &value[HI:LO];
    end

    assign boxed = &level_ok;

endmodule

// File: rtl/hbox_sext.sv
module hbox_sext #(
    parameter int XLEN = 64
) (
    input  logic [15:0]     half,
    output logic [XLEN-1:0] wide
);
    localparam int PAD = XLEN - 16;

    assign wide = {{PAD{half[15]}}, half};

endmodule

// File: rtl/hbox_move_unit.sv
module hbox_move_unit
    import hbox_pkg::*;
#(
    parameter int FLEN = 64,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [1:0]      fmt,
    input  logic [FLEN-1:0] frs_data,
    input  logic [XLEN-1:0] xrs_data,
    input  logic [15:0]     ld_data,
    output logic            out_valid,
    output logic [FLEN-1:0] f_result,
    output logic [XLEN-1:0] x_result,
    output logic [15:0]     st_data,
    output logic [FLEN-1:0] chk_operand,
    output logic            box_ok
);
    localparam int BOX_W = FLEN - HALF_W;
    localparam logic [BOX_W-1:0] BOX_ONES = '1;

    typedef struct packed {
        logic            valid;
        logic [FLEN-1:0] f_res;
        logic [XLEN-1:0] x_res;
        logic [15:0]     st;
        logic [FLEN-1:0] chk;
        logic            ok;
    } state_t;

    state_t   state_d, state_q;
    hbox_op_e op_sel;
    logic     frs_boxed;
    logic [XLEN-1:0] sext_val;
    logic [XLEN-1:0] unused_xrs;

    assign op_sel     = hbox_op_e'(op);
    assign unused_xrs = xrs_data;

    hbox_box_check #(.FLEN(FLEN)) i_box_check (
        .value (frs_data),
        .boxed (frs_boxed)
    );

    hbox_sext #(.XLEN(XLEN)) i_sext (
        .half (frs_data[15:0]),
        .wide (sext_val)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.f_res = '0;
            state_d.x_res = '0;
            state_d.st    = '0;
            unique case (op_sel)
                OP_LOAD:     state_d.f_res = {BOX_ONES, ld_data};
                OP_STORE:    state_d.st    = frs_data[15:0];
                OP_TO_INT:   state_d.x_res = sext_val;
                OP_FROM_INT: state_d.f_res = {BOX_ONES, xrs_data[15:0]};
                default:     state_d.f_res = '0;
            endcase
            if (fmt == FMT_HALF) begin
                state_d.ok  = frs_boxed;
                state_d.chk = frs_boxed ? frs_data : {BOX_ONES, CANON_NAN};
            end else begin
                state_d.ok  = 1'b0;
                state_d.chk = frs_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign f_result    = state_q.f_res;
    assign x_result    = state_q.x_res;
    assign st_data     = state_q.st;
    assign chk_operand = state_q.chk;
    assign box_ok      = state_q.ok;

    // R2: a presented operation yields a valid strobe on the next edge
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3: load result is boxed and carries the memory word
    p_load_boxed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00) |=>
            (&f_result[FLEN-1:16]) && f_result[15:0] == $past(ld_data));

    // R4: store data is the low half of the source
    p_store_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01) |=> st_data == $past(frs_data[15:0]));

    // R5: integer result upper bits all match the half sign
    p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10) |=>
            ((&x_result[XLEN-1:15]) || !(|x_result[XLEN-1:15])) &&
            x_result[15:0] == $past(frs_data[15:0]));

    // R6: move-from-integer result is boxed
    p_from_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=>
            (&f_result[FLEN-1:16]) && f_result[15:0] == $past(xrs_data[15:0]));

    // R8: a rejected half operand becomes the boxed canonical NaN
    p_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b10 && !(&frs_data[FLEN-1:16])) |=>
            !box_ok && chk_operand == {BOX_ONES, 16'h7E00});

    // R11: idle cycles leave results untouched
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(f_result) && $stable(x_result) &&
                      $stable(st_data) && $stable(chk_operand));

endmodule

// File: tb/test_hbox_move_unit.sv
module test_hbox_move_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  fmt;
        logic [63:0] frs;
        logic [63:0] xrs;
        logic [15:0] ld;
        logic [63:0] ef;
        logic [63:0] ex;
        logic [15:0] est;
        logic [63:0] echk;
        logic        eok;
    } vec_t;

    // op, fmt, frs, xrs, ld, exp f, exp x, exp st, exp chk, exp ok
    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'b00, 64'h0, 64'h0, 16'h3C00,
          64'hFFFF_FFFF_FFFF_3C00, 64'h0, 16'h0, 64'h0, 1'b0},
        '{2'b00, 2'b10, 64'hFFFF_FFFF_FFFF_1234, 64'h0, 16'h7C01,
          64'hFFFF_FFFF_FFFF_7C01, 64'h0, 16'h0, 64'hFFFF_FFFF_FFFF_1234, 1'b1},
        '{2'b01, 2'b10, 64'h0123_4567_89AB_CDEF, 64'h0, 16'h0,
          64'h0, 64'h0, 16'hCDEF, 64'hFFFF_FFFF_FFFF_7E00, 1'b0},
        '{2'b01, 2'b10, 64'hFFFF_FFFF_FFFF_8001, 64'h0, 16'h0,
          64'h0, 64'h0, 16'h8001, 64'hFFFF_FFFF_FFFF_8001, 1'b1},
        '{2'b10, 2'b10, 64'h0000_0000_0000_8000, 64'h0, 16'h0,
          64'h0, 64'hFFFF_FFFF_FFFF_8000, 16'h0, 64'hFFFF_FFFF_FFFF_7E00, 1'b0},
        '{2'b10, 2'b10, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, 16'h0,
          64'h0, 64'h0000_0000_0000_7FFF, 16'h0, 64'hFFFF_FFFF_FFFF_7FFF, 1'b1},
        '{2'b10, 2'b10, 64'hFFFF_FFFF_0000_7D55, 64'h0, 16'h0,
          64'h0, 64'h0000_0000_0000_7D55, 16'h0, 64'hFFFF_FFFF_FFFF_7E00, 1'b0},
        '{2'b11, 2'b10, 64'hFFFF_FFFF_FFFE_0000, 64'hDEAD_BEEF_CAFE_FE01, 16'h0,
          64'hFFFF_FFFF_FFFF_FE01, 64'h0, 16'h0, 64'hFFFF_FFFF_FFFF_7E00, 1'b0},
        '{2'b11, 2'b10, 64'h7FFF_FFFF_FFFF_0000, 64'h0, 16'h0,
          64'hFFFF_FFFF_FFFF_0000, 64'h0, 16'h0, 64'hFFFF_FFFF_FFFF_7E00, 1'b0},
        '{2'b00, 2'b01, 64'hFFFF_FFFF_0000_0000, 64'h0, 16'hFFFF,
          64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 64'hFFFF_FFFF_0000_0000, 1'b0},
        '{2'b10, 2'b11, 64'hFFFF_FFFF_FFFF_FE00, 64'h0, 16'h0,
          64'h0, 64'hFFFF_FFFF_FFFF_FE00, 16'h0, 64'hFFFF_FFFF_FFFF_FE00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  fmt = '0;
    logic [63:0] frs_data = '0;
    logic [63:0] xrs_data = '0;
    logic [15:0] ld_data = '0;
    logic        out_valid;
    logic [63:0] f_result;
    logic [63:0] x_result;
    logic [15:0] st_data;
    logic [63:0] chk_operand;
    logic        box_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbox_move_unit #(.FLEN(64), .XLEN(64)) i_hbox_move_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt(fmt),
        .frs_data(frs_data), .xrs_data(xrs_data), .ld_data(ld_data),
        .out_valid(out_valid), .f_result(f_result), .x_result(x_result),
        .st_data(st_data), .chk_operand(chk_operand), .box_ok(box_ok)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; fmt = v.fmt; frs_data = v.frs; xrs_data = v.xrs; ld_data = v.ld;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string r;
        r = (v.op == 2'b00) ? "R3" : (v.op == 2'b01) ? "R4" :
            (v.op == 2'b10) ? "R5" : "R6";
        check("R2", $sformatf("v%0d out_valid", idx), {63'b0, out_valid}, 64'd1);
        check(r, $sformatf("v%0d f_result (R10)", idx), f_result, v.ef);
        check(r, $sformatf("v%0d x_result (R10)", idx), x_result, v.ex);
        check(r, $sformatf("v%0d st_data (R10)", idx), {48'b0, st_data}, {48'b0, v.est});
        check(v.fmt != 2'b10 ? "R9" : (v.eok ? "R7" : "R8"),
              $sformatf("v%0d chk_operand", idx), chk_operand, v.echk);
        check(v.fmt != 2'b10 ? "R9" : (v.eok ? "R7" : "R8"),
              $sformatf("v%0d box_ok", idx), {63'b0, box_ok}, {63'b0, v.eok});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid in reset", {63'b0, out_valid}, 64'd0);
        check("R1", "f_result in reset", f_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", {63'b0, out_valid}, 64'd0);
        check("R1", "results after reset", f_result | x_result | chk_operand | {48'b0, st_data}, 64'd0);
        check("R1", "box_ok after reset", {63'b0, box_ok}, 64'd0);

        // Table walk: one operation per pulse, checked at the next falling edge
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VECS[i], i);
        end

        // R11: idle cycles with changed inputs keep the last results
        frs_data = 64'h1111_2222_3333_4444; xrs_data = 64'h5; ld_data = 16'hAAAA; op = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check("R11", "out_valid idle", {63'b0, out_valid}, 64'd0);
        check("R11", "x_result held", x_result, VECS[NV-1].ex);
        check("R11", "chk_operand held", chk_operand, VECS[NV-1].echk);
        check("R11", "f_result held", f_result, 64'd0);

        // R2: back-to-back operations, each seen one edge later
        drive(VECS[1]);
        in_valid = 1'b1;
        @(negedge clk);
        check_vec(VECS[1], 101);
        drive(VECS[4]);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[4], 104);
        @(negedge clk);
        check("R2", "strobe drops after burst", {63'b0, out_valid}, 64'd0);

        // R4: store of a broken box with NaN payload ignores upper bits
        op = 2'b01; fmt = 2'b10; frs_data = 64'h0000_0000_0000_7D01;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4", "store unboxed NaN payload", {48'b0, st_data}, 64'h7D01);
        check("R8", "store operand flagged", {63'b0, box_ok}, 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule